// File: doc/BRIEF.md
# Pointer Literal-Subtract and Return Unit

This execution unit serves a small 8-bit microcontroller core. It owns three 12-bit indirect-address pointer registers and carries out one opcode family, `1110 1001 ss kkkkkk`. The 2-bit selector `s` (instruction bits [7:6]) picks the variant and the 6-bit unsigned literal `k` (bits [5:0]) is the amount subtracted. Selector values 0, 1 and 2 subtract `k` from the pointer with that index, within a single instruction cycle. Selector value 3 subtracts `k` from pointer 2 and then returns from a subroutine. The return needs a second instruction cycle, and that cycle does no other work.

Each instruction cycle is one clock period here. The decode strobe qualifies the instruction word. A write to a pointer takes effect on the clock edge that ends the decode cycle. The return variant also latches the top-of-stack address at decode. In the cycle that follows, the unit asserts the PC-load, stack-pop and flush requests together, keeps busy high, and drives the latched address as the PC target. Any word presented in that second cycle is the prefetched instruction, which the flush discards, so the unit ignores it. No status flag is produced.

Control is a two-state machine:
- `ST_DECODE` accepts instructions.
- `ST_RETURN` is the return slot.

The machine has three transitions:
- `T_RET_ISSUE` goes from `ST_DECODE` to `ST_RETURN` on a qualified return-variant word.
- `T_RET_DONE` goes from `ST_RETURN` to `ST_DECODE` unconditionally.
- `T_STAY` keeps `ST_DECODE` for every other input.

A synchronous reset returns the machine to `ST_DECODE`.

Top module: `ptr_sub_ret_unit`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, all three pointers become 0 after that edge. The same edge puts the machine in ST_DECODE, so `pc_load_o`, `stack_pop_o`, `flush_o` and `busy_o` are 0 and `pc_target_o` is 0. This also holds when reset arrives during the return slot.
- R2: A word is qualified when `instr_valid_i` is 1, bits [15:8] equal E9h and `busy_o` is 0. If bits [7:6] are 0, 1 or 2, the pointer with that index becomes its old value minus bits [5:0] after the next edge, and the other two pointers keep their values.
- R3: Subtraction is modulo 4096 with no borrow output. For example, 000h minus 5 gives FFBh, and 000h minus 63 gives FC1h.
- R4: The plain variant (selector 0 to 2) finishes in one cycle. Busy, PC-load, pop and flush stay 0, and a qualified word in the very next cycle is executed.
- R5: For selector 3 (bits [7:6] = 11), only pointer 2 is reduced by `k`. Pointers 0 and 1 keep their values.
- R6: In the cycle after a qualified selector-3 word, `pc_load_o`, `stack_pop_o`, `flush_o` and `busy_o` are all 1, and `pc_target_o` equals the `tos_i` value present at decode. All four signals are 1 for exactly one cycle.
- R7: Any word presented while `busy_o` is 1 is discarded: no pointer changes and no new return starts.
- R8: When `instr_valid_i` is 0, or when bits [15:8] differ from E9h, no pointer changes and the request outputs stay 0.
- R9: With pointer 2 at 3FFh, a selector-2 word with k = 23h leaves pointer 2 at 3DCh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period per instruction cycle |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid_i | input | 1 | Decode strobe qualifying `instr_i` |
| instr_i | input | 16 | Instruction word |
| tos_i | input | PC_W (16) | Current top-of-stack return address |
| pc_load_o | output | 1 | PC-load request (return slot) |
| pc_target_o | output | PC_W (16) | PC target address, valid with `pc_load_o`, else 0 |
| stack_pop_o | output | 1 | Return-stack pop request |
| flush_o | output | 1 | Discard the prefetched instruction |
| busy_o | output | 1 | Unit occupied by the second cycle of a return |
| ptr0_o | output | PTR_W (12) | Pointer register 0 |
| ptr1_o | output | PTR_W (12) | Pointer register 1 |
| ptr2_o | output | PTR_W (12) | Pointer register 2 |

## Verification
The return slot and the decode of a fresh word can land in the same cycle, because the front end keeps presenting prefetched words while the return runs. The bench provokes this overlap in two ways. It holds the strobe high with a plain subtract in the slot, and it holds the strobe high with another return word in the slot. It judges the result by checking that pointers stay put, that the requests fall after one cycle, and that the next word after the slot executes normally. A reset landing in that same slot is also driven. In that case the requests must drop at once.

// File: rtl/ptrsub_pkg.sv
`timescale 1ns/1ps
package ptrsub_pkg;
    localparam int INSTR_W = 16;
    localparam int PFX_W   = 8;
    localparam int SEL_W   = 2;
    localparam int LIT_W   = 6;
    localparam int NUM_PTR = 3;
    localparam int RET_PTR = 2;
    localparam logic [PFX_W-1:0] OPC_PREFIX = 8'hE9;
    localparam logic [SEL_W-1:0] SEL_RET    = 2'b11;

    typedef enum logic [0:0] {
        ST_DECODE = 1'b0,
        ST_RETURN = 1'b1
    } ctrl_state_e;
endpackage

// File: rtl/ptrsub_decode.sv
`timescale 1ns/1ps
module ptrsub_decode
    import ptrsub_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               valid_i,
    input  logic               accept_i,
    output logic               wr_en_o,
    output logic [SEL_W-1:0]   wr_sel_o,
    output logic [LIT_W-1:0]   lit_o,
    output logic               ret_go_o
);
    logic             prefix_hit;
    logic [SEL_W-1:0] field;
    logic             qualified;

    always_comb begin
        prefix_hit = (instr_i[INSTR_W-1 -: PFX_W] == OPC_PREFIX);
        field      = instr_i[LIT_W +: SEL_W];
        qualified  = valid_i && accept_i && prefix_hit;
        ret_go_o   = qualified && (field == SEL_RET);
        wr_en_o    = qualified;
        wr_sel_o   = (field == SEL_RET) ? SEL_W'(RET_PTR) : field;
        lit_o      = instr_i[LIT_W-1:0];
    end
endmodule

// File: rtl/ptrsub_ptrfile.sv
`timescale 1ns/1ps
module ptrsub_ptrfile
    import ptrsub_pkg::*;
#(
    parameter int PTR_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en_i,
    input  logic [SEL_W-1:0]         wr_sel_i,
    input  logic [LIT_W-1:0]         lit_i,
    output logic [NUM_PTR*PTR_W-1:0] ptr_flat_o
);
    localparam int PAD_W = PTR_W - LIT_W;

    logic [PTR_W-1:0] lit_ext;

    always_comb begin
        lit_ext = {{PAD_W{1'b0}}, lit_i};
    end

    for (genvar gi = 0; gi < NUM_PTR; gi++) begin : g_ptr
        logic [PTR_W-1:0] ptr_q;
        logic [PTR_W-1:0] ptr_dec;
        logic             hit;

        always_comb begin
            hit     = wr_en_i && (wr_sel_i == SEL_W'(gi));
            ptr_dec = ptr_q - lit_ext;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q <= '0;
            end else if (hit) begin
                ptr_q <= ptr_dec;
            end
        end

        assign ptr_flat_o[gi*PTR_W +: PTR_W] = ptr_q;
    end
endmodule

// File: rtl/ptrsub_ctrl.sv
`timescale 1ns/1ps
module ptrsub_ctrl
    import ptrsub_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ret_go_i,
    input  logic [PC_W-1:0] tos_i,
    output logic            busy_o,
    output logic            pc_load_o,
    output logic [PC_W-1:0] pc_target_o,
    output logic            stack_pop_o,
    output logic            flush_o
);
    ctrl_state_e     state_q;
    ctrl_state_e     state_d;
    logic [PC_W-1:0] tos_q;

    // Next state: T_RET_ISSUE, T_RET_DONE, T_STAY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DECODE: if (ret_go_i) state_d = ST_RETURN;
            ST_RETURN: state_d = ST_DECODE;
            default:   state_d = ST_DECODE;
        endcase
    end

    // State register and return-address latch
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_DECODE;
            tos_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_DECODE && ret_go_i) begin
                tos_q <= tos_i;
            end
        end
    end

    // Outputs by state
    always_comb begin
        busy_o      = 1'b0;
        pc_load_o   = 1'b0;
        stack_pop_o = 1'b0;
        flush_o     = 1'b0;
        pc_target_o = '0;
        unique case (state_q)
            ST_DECODE: begin
            end
            ST_RETURN: begin
                busy_o      = 1'b1;
                pc_load_o   = 1'b1;
                stack_pop_o = 1'b1;
                flush_o     = 1'b1;
                pc_target_o = tos_q;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/ptr_sub_ret_unit.sv
`timescale 1ns/1ps
module ptr_sub_ret_unit
    import ptrsub_pkg::*;
#(
    parameter int PTR_W = 12,
    parameter int PC_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [PC_W-1:0]    tos_i,
    output logic               pc_load_o,
    output logic [PC_W-1:0]    pc_target_o,
    output logic               stack_pop_o,
    output logic               flush_o,
    output logic               busy_o,
    output logic [PTR_W-1:0]   ptr0_o,
    output logic [PTR_W-1:0]   ptr1_o,
    output logic [PTR_W-1:0]   ptr2_o
);
    logic                     wr_en;
    logic [SEL_W-1:0]         wr_sel;
    logic [LIT_W-1:0]         lit;
    logic                     ret_go;
    logic                     busy;
    logic [NUM_PTR*PTR_W-1:0] ptr_flat;

    ptrsub_decode u_decode (
        .instr_i  (instr_i),
        .valid_i  (instr_valid_i),
        .accept_i (!busy),
        .wr_en_o  (wr_en),
        .wr_sel_o (wr_sel),
        .lit_o    (lit),
        .ret_go_o (ret_go)
    );

    ptrsub_ptrfile #(.PTR_W(PTR_W)) u_ptrfile (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en),
        .wr_sel_i   (wr_sel),
        .lit_i      (lit),
        .ptr_flat_o (ptr_flat)
    );

    ptrsub_ctrl #(.PC_W(PC_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ret_go_i    (ret_go),
        .tos_i       (tos_i),
        .busy_o      (busy),
        .pc_load_o   (pc_load_o),
        .pc_target_o (pc_target_o),
        .stack_pop_o (stack_pop_o),
        .flush_o     (flush_o)
    );

    assign busy_o = busy;
    assign ptr0_o = ptr_flat[0*PTR_W +: PTR_W];
    assign ptr1_o = ptr_flat[1*PTR_W +: PTR_W];
    assign ptr2_o = ptr_flat[2*PTR_W +: PTR_W];
endmodule

// File: rtl/ptrsub_checker.sv
`timescale 1ns/1ps
module ptrsub_checker #(
    parameter int PTR_W = 12,
    parameter int PC_W  = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             instr_valid_i,
    input logic [15:0]      instr_i,
    input logic [PC_W-1:0]  tos_i,
    input logic             pc_load_o,
    input logic [PC_W-1:0]  pc_target_o,
    input logic             stack_pop_o,
    input logic             flush_o,
    input logic             busy_o,
    input logic [PTR_W-1:0] ptr0_o,
    input logic [PTR_W-1:0] ptr1_o,
    input logic [PTR_W-1:0] ptr2_o
);
    logic             hit;
    logic [1:0]       f;
    logic [PTR_W-1:0] kx;
    logic             rst_d;

    always_comb begin
        hit = instr_valid_i && (instr_i[15:8] == 8'hE9) && !busy_o;
        f   = instr_i[7:6];
        kx  = {{(PTR_W-6){1'b0}}, instr_i[5:0]};
    end

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d) begin
            p_reset_clear_r1: assert (ptr0_o == '0 && ptr1_o == '0 && ptr2_o == '0 &&
                                      !pc_load_o && !stack_pop_o && !flush_o && !busy_o);
        end
    end

    p_sub_p0_r2: assert property (@(posedge clk) disable iff (rst)
        hit && f == 2'd0 |=> ptr0_o == ($past(ptr0_o) - $past(kx)) && $stable(ptr1_o) && $stable(ptr2_o));

    p_sub_p1_r2: assert property (@(posedge clk) disable iff (rst)
        hit && f == 2'd1 |=> ptr1_o == ($past(ptr1_o) - $past(kx)) && $stable(ptr0_o) && $stable(ptr2_o));

    p_sub_p2_r2: assert property (@(posedge clk) disable iff (rst)
        hit && f == 2'd2 |=> ptr2_o == ($past(ptr2_o) - $past(kx)) && $stable(ptr0_o) && $stable(ptr1_o));

    p_plain_no_busy_r4: assert property (@(posedge clk) disable iff (rst)
        hit && f != 2'd3 |=> !busy_o && !pc_load_o);

    p_ret_sub_r5: assert property (@(posedge clk) disable iff (rst)
        hit && f == 2'd3 |=> ptr2_o == ($past(ptr2_o) - $past(kx)) && $stable(ptr0_o) && $stable(ptr1_o));

    p_ret_outputs_r6: assert property (@(posedge clk) disable iff (rst)
        hit && f == 2'd3 |=> pc_load_o && stack_pop_o && flush_o && busy_o && pc_target_o == $past(tos_i));

    p_ret_one_shot_r6: assert property (@(posedge clk) disable iff (rst)
        pc_load_o |=> !pc_load_o && !stack_pop_o && !flush_o && !busy_o);

    p_slot_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(ptr0_o) && $stable(ptr1_o) && $stable(ptr2_o));

    p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        (!instr_valid_i || instr_i[15:8] != 8'hE9) && !busy_o |=>
            $stable(ptr0_o) && $stable(ptr1_o) && $stable(ptr2_o) && !pc_load_o);
endmodule

bind ptr_sub_ret_unit ptrsub_checker #(.PTR_W(PTR_W), .PC_W(PC_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .instr_valid_i (instr_valid_i),
    .instr_i       (instr_i),
    .tos_i         (tos_i),
    .pc_load_o     (pc_load_o),
    .pc_target_o   (pc_target_o),
    .stack_pop_o   (stack_pop_o),
    .flush_o       (flush_o),
    .busy_o        (busy_o),
    .ptr0_o        (ptr0_o),
    .ptr1_o        (ptr1_o),
    .ptr2_o        (ptr2_o)
);

// File: tb/ptr_sub_ret_unit_tb.sv
`timescale 1ns/1ps
module ptr_sub_ret_unit_tb;
    localparam int PTR_W = 12;
    localparam int PC_W  = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             instr_valid = 1'b0;
    logic [15:0]      instr = '0;
    logic [PC_W-1:0]  tos = '0;
    logic             pc_load, stack_pop, flush, busy;
    logic [PC_W-1:0]  pc_target;
    logic [PTR_W-1:0] ptr0, ptr1, ptr2;

    always #4 clk = ~clk;

    ptr_sub_ret_unit #(.PTR_W(PTR_W), .PC_W(PC_W)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .instr_valid_i (instr_valid),
        .instr_i       (instr),
        .tos_i         (tos),
        .pc_load_o     (pc_load),
        .pc_target_o   (pc_target),
        .stack_pop_o   (stack_pop),
        .flush_o       (flush),
        .busy_o        (busy),
        .ptr0_o        (ptr0),
        .ptr1_o        (ptr1),
        .ptr2_o        (ptr2)
    );

    typedef struct {
        logic [PTR_W-1:0] p0, p1, p2;
        logic             ld, pop, fl, bz;
        logic [PC_W-1:0]  tgt;
        string            tag;
    } exp_t;

    exp_t             sb_q[$];
    int               n_cmp = 0;
    int               n_bad = 0;
    bit               done  = 0;
    logic [PTR_W-1:0] m_p[3] = '{default: '0};
    bit               m_pend = 0;
    logic [PC_W-1:0]  m_tos = '0;

    function automatic logic [15:0] op(input logic [1:0] f, input logic [5:0] k);
        return {8'hE9, f, k};
    endfunction

    // Driver: applies one cycle of stimulus and pushes the expected post-edge state
    task automatic step(input bit r, input bit v, input logic [15:0] w,
                        input logic [PC_W-1:0] t, input string tag);
        exp_t e;
        logic [PTR_W-1:0] kx;
        @(negedge clk);
        rst = r; instr_valid = v; instr = w; tos = t;
        kx = {6'b0, w[5:0]};
        if (r) begin
            m_p = '{default: '0};
            m_pend = 0;
        end else if (m_pend) begin
            m_pend = 0;
        end else if (v && w[15:8] == 8'hE9) begin
            if (w[7:6] == 2'b11) begin
                m_p[2] = m_p[2] - kx;
                m_pend = 1;
                m_tos  = t;
            end else begin
                m_p[w[7:6]] = m_p[w[7:6]] - kx;
            end
        end
        e.p0 = m_p[0]; e.p1 = m_p[1]; e.p2 = m_p[2];
        e.ld = m_pend; e.pop = m_pend; e.fl = m_pend; e.bz = m_pend;
        e.tgt = m_pend ? m_tos : '0;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compares just after each edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                n_cmp++;
                if (ptr0 !== e.p0 || ptr1 !== e.p1 || ptr2 !== e.p2 ||
                    pc_load !== e.ld || stack_pop !== e.pop || flush !== e.fl ||
                    busy !== e.bz || pc_target !== e.tgt) begin
                    n_bad++;
                    $display("FAIL %s: got p=%h/%h/%h ld=%b pop=%b fl=%b bz=%b tgt=%h exp p=%h/%h/%h ld=%b pop=%b fl=%b bz=%b tgt=%h",
                             e.tag, ptr0, ptr1, ptr2, pc_load, stack_pop, flush, busy, pc_target,
                             e.p0, e.p1, e.p2, e.ld, e.pop, e.fl, e.bz, e.tgt);
                end
            end
        end
    end

    initial begin
        #800000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): got hang, exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        step(1, 0, 16'h0000, 16'h0000, "R1 reset");
        step(1, 1, op(2'd0, 6'd3), 16'h0000, "R1 reset holds");
        step(0, 1, op(2'd0, 6'd5), 16'h0000, "R3 wrap p0 0-5");
        step(0, 1, op(2'd1, 6'd63), 16'h0000, "R3 wrap p1 0-63");
        step(0, 1, op(2'd2, 6'd1), 16'h0000, "R3 wrap p2 0-1");
        while (int'(m_p[2]) - 'h3FF > 63)
            step(0, 1, op(2'd2, 6'd63), 16'h0000, "R2 walk p2");
        step(0, 1, op(2'd2, 6'(int'(m_p[2]) - 'h3FF)), 16'h0000, "R2 land p2 at 3FF");
        step(0, 1, op(2'd2, 6'h23), 16'h0000, "R9 3FF-23 = 3DC");
        step(0, 1, op(2'd0, 6'd0), 16'h0000, "R2 k=0 no change");
        step(0, 1, op(2'd1, 6'd17), 16'h0000, "R4 back-to-back first");
        step(0, 1, op(2'd0, 6'd9), 16'h0000, "R4 back-to-back second");
        step(0, 0, op(2'd0, 6'd9), 16'h0000, "R8 strobe low");
        step(0, 1, 16'hE849, 16'h0000, "R8 prefix E8");
        step(0, 1, 16'hF9C3, 16'h0000, "R8 prefix F9");
        step(0, 1, 16'h0000, 16'h0000, "R8 zero word");
        step(0, 1, op(2'd3, 6'h23), 16'h1234, "R5 R6 return issue");
        step(0, 1, op(2'd0, 6'd7), 16'hBEEF, "R7 plain word in slot ignored");
        step(0, 1, op(2'd3, 6'd0), 16'hA5A5, "R6 return k=0");
        step(0, 0, 16'h0000, 16'h0000, "R6 requests drop after one cycle");
        step(0, 1, op(2'd3, 6'd63), 16'h0F0F, "R5 return k=63");
        step(0, 1, op(2'd3, 6'd1), 16'h1111, "R7 return word in slot ignored");
        step(0, 1, op(2'd1, 6'd2), 16'h0000, "R4 accepted right after slot");
        step(0, 1, op(2'd3, 6'd5), 16'h7777, "R6 return before reset");
        step(1, 1, op(2'd0, 6'd1), 16'h0000, "R1 reset in return slot");
        step(0, 0, 16'h0000, 16'h0000, "R1 idle after reset");
        @(posedge clk);
        #2;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule